// File: doc/BRIEF.md
# SPI Shift Engine with Selectable Output Edge and Sample Phase

This block moves one byte at a time over a four-wire serial link, either as the clock-generating master or as a slave driven by an external clock. The clock's resting level is programmable. A separate control bit chooses whether the outgoing bit changes on the edge that leaves the resting level (leading) or on the one that returns to it (trailing). In master mode the incoming bit can be captured either at the capture edge in the middle of each bit window or on the last system clock before the outgoing bit changes.

A host starts a master transfer by writing a byte. The byte leaves on `sdo` most significant bit first while `sdi` is gathered into the same shifter. After eight serial clock cycles the received byte is placed in the receive buffer and `buf_full` rises. In slave mode a write preloads the outgoing byte while the select line is inactive. The transfer then follows the external clock while `ss_n` is low.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset `buf_full`, `busy` and `wcol` are 0, and while no master transfer runs `sck_o` rests at the level of `idle_high` (1 = rests high).
- R2: In master mode with `sample_end`=0, `sdi` is captured at the capture edge in the middle of each bit window. The capture edge is the edge opposite the output-change edge.
- R3: In master mode with `sample_end`=1, `sdi` is captured on the last system clock before the next output change (the end of the bit window).
- R4: `sdo` carries the written byte most significant bit first. During a master transfer it changes only together with an `sck_o` edge. With `tx_lead`=1 that is the edge leaving the resting level: rising when `idle_high`=0, falling when `idle_high`=1. With `tx_lead`=0 it is the edge returning to the resting level.
- R5: A master transfer produces exactly 8 serial clock cycles (16 transitions of `sck_o`), and `sck_o` ends at its resting level.
- R6: When a byte has been fully received, `rd_data` holds it and `buf_full` becomes 1. A cycle with `rd_en`=1 clears `buf_full`.
- R7: A write while `busy`=1 does not alter the byte being sent or received and sets `wcol` to 1. The next accepted write clears `wcol`.
- R8: In slave mode (`mode_master`=0) the engine follows `sck_i` while `ss_n` is low, using the same edge rules as R4. Data is captured on the opposite edge. After the eighth capture edge the received byte goes to `rd_data` and `buf_full` rises.
- R9: In slave mode `sample_end` is ignored. The received and sent bytes are the same as with `sample_end`=0.
- R10: Each half-period of `sck_o` lasts `half_div`+1 system clocks. `buf_full` rises 16*(`half_div`+1) clocks after the edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_master | input | 1 | 1 = master, 0 = slave |
| idle_high | input | 1 | Resting level of the serial clock |
| tx_lead | input | 1 | 1 = output changes on leading edge, 0 = on trailing edge |
| sample_end | input | 1 | Master only: 1 = capture at end of bit window |
| half_div | input | 4 | Half-period of serial clock minus one, in system clocks |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to send |
| rd_en | input | 1 | Host read strobe, clears buf_full |
| rd_data | output | 8 | Last received byte |
| buf_full | output | 1 | Received byte waiting |
| busy | output | 1 | Transfer in progress (slave: select active) |
| wcol | output | 1 | Write collided with a running transfer |
| sck_o | output | 1 | Serial clock driven in master mode |
| sdo | output | 1 | Serial data out |
| sck_i | input | 1 | Serial clock from an external master |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |

## Verification
On every cycle the checker confirms several relations. A master `sdo` change coincides with an `sck_o` edge of the selected kind. The clock rests at its idle level when nothing runs. Reads clear the full flag, and colliding writes raise `wcol`. A counter confirms that each master transfer lasts 16*(`half_div`+1) cycles. Which instant `sdi` is captured at, and the byte values themselves, only the bench scenarios can show. There a peer model drives a decoy bit in the half of each bit window that must not be sampled. The slave scenarios confirm that `sample_end` changes nothing.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef struct packed {
        logic idle_high;
        logic tx_lead;
        logic sample_end;
    } spi_timing_t;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } spi_role_e;

    // serial clock level during a half period of the given parity
    function automatic logic sck_level(input logic idle, input logic lead, input logic odd_half);
        return idle ^ (lead ? ~odd_half : odd_half);
    endfunction

    // an edge that lands on new_lvl is the output-change edge
    function automatic logic is_tx_edge(input logic idle, input logic lead, input logic new_lvl);
        return ((new_lvl != idle) == lead);
    endfunction

endpackage

// File: rtl/spi_master_timer.sv
module spi_master_timer
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] half_div,
    input  logic             idle_high,
    input  logic             tx_lead,
    output logic             run,
    output logic             sck,
    output logic             mid_ev,
    output logic             shift_ev,
    output logic             last_half
);
    localparam int HALVES = 2 * DATA_W;
    localparam int HW     = $clog2(HALVES);

    logic [DIV_W-1:0] cnt;
    logic [HW-1:0]    half;
    logic             tick;

    assign tick      = run && (cnt == half_div);
    assign mid_ev    = tick && !half[0];
    assign shift_ev  = tick && half[0];
    assign last_half = (half == HW'(HALVES - 1));
    assign sck       = run ? sck_level(idle_high, tx_lead, half[0]) : idle_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            cnt  <= '0;
            half <= '0;
        end else if (start) begin
            run  <= 1'b1;
            cnt  <= '0;
            half <= '0;
        end else if (run) begin
            if (cnt == half_div) begin
                cnt <= '0;
                if (last_half) run  <= 1'b0;
                else           half <= half + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front
    import spi_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic idle_high,
    input  logic tx_lead,
    input  logic sck_i,
    input  logic ss_n,
    input  logic sdi,
    output logic active,
    output logic cap_ev,
    output logic sh_ev,
    output logic sdi_s
);
    logic [2:0] sck_q;
    logic [1:0] sdi_q;
    logic [1:0] ss_q;
    logic       edge_seen;
    logic       tx_kind;

    assign active    = !ss_q[1];
    assign sdi_s     = sdi_q[1];
    assign edge_seen = sck_q[1] ^ sck_q[2];
    assign tx_kind   = is_tx_edge(idle_high, tx_lead, sck_q[1]);
    assign sh_ev     = active && edge_seen && tx_kind;
    assign cap_ev    = active && edge_seen && !tx_kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= {3{idle_high}};
            sdi_q <= '0;
            ss_q  <= 2'b11;
        end else begin
            sck_q <= {sck_q[1:0], sck_i};
            sdi_q <= {sdi_q[0], sdi};
            ss_q  <= {ss_q[0], ss_n};
        end
    end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_master,
    input  logic              idle_high,
    input  logic              tx_lead,
    input  logic              sample_end,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              busy,
    output logic              wcol,
    output logic              sck_o,
    output logic              sdo,
    input  logic              sck_i,
    input  logic              ss_n,
    input  logic              sdi
);
    localparam int BW = $clog2(DATA_W);

    spi_timing_t cfg;
    spi_role_e   role;

    logic m_run, m_sck, m_mid, m_shift, m_last;
    logic s_active, s_cap, s_sh, s_sdi;
    logic accept, start, bit_in;

    logic [DATA_W-1:0] sh, rxbuf;
    logic              samp, pend;
    logic [BW-1:0]     sbits;

    assign cfg    = '{idle_high: idle_high, tx_lead: tx_lead, sample_end: sample_end};
    assign role   = spi_role_e'(mode_master);
    assign busy   = (role == ROLE_MASTER) ? m_run : s_active;
    assign accept = wr_en && !busy;
    assign start  = accept && (role == ROLE_MASTER);
    assign bit_in = cfg.sample_end ? sdi : samp;

    spi_master_timer #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst(rst), .start(start), .half_div(half_div),
        .idle_high(cfg.idle_high), .tx_lead(cfg.tx_lead),
        .run(m_run), .sck(m_sck), .mid_ev(m_mid), .shift_ev(m_shift), .last_half(m_last)
    );

    spi_slave_front u_front (
        .clk(clk), .rst(rst), .idle_high(cfg.idle_high), .tx_lead(cfg.tx_lead),
        .sck_i(sck_i), .ss_n(ss_n), .sdi(sdi),
        .active(s_active), .cap_ev(s_cap), .sh_ev(s_sh), .sdi_s(s_sdi)
    );

    assign sck_o    = (role == ROLE_MASTER) ? m_sck : cfg.idle_high;
    assign sdo      = sh[DATA_W-1];
    assign rd_data  = rxbuf;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            rxbuf    <= '0;
            buf_full <= 1'b0;
            wcol     <= 1'b0;
            samp     <= 1'b0;
            pend     <= 1'b0;
            sbits    <= '0;
        end else begin
            if (rd_en) buf_full <= 1'b0;
            if (wr_en) begin
                if (busy) begin
                    wcol <= 1'b1;
                end else begin
                    sh   <= wr_data;
                    wcol <= 1'b0;
                end
            end
            if (role == ROLE_MASTER) begin
                if (m_mid && !cfg.sample_end) samp <= sdi;
                if (m_shift) begin
                    if (m_last) begin
                        rxbuf    <= {sh[DATA_W-2:0], bit_in};
                        buf_full <= 1'b1;
                    end else begin
                        sh <= {sh[DATA_W-2:0], bit_in};
                    end
                end
            end else if (!s_active) begin
                sbits <= '0;
                pend  <= 1'b0;
            end else begin
                if (s_cap) begin
                    if (sbits == BW'(DATA_W - 1)) begin
                        rxbuf    <= {sh[DATA_W-2:0], s_sdi};
                        buf_full <= 1'b1;
                        sbits    <= '0;
                        pend     <= 1'b0;
                    end else begin
                        samp  <= s_sdi;
                        pend  <= 1'b1;
                        sbits <= sbits + 1'b1;
                    end
                end
                if (s_sh && pend) begin
                    sh   <= {sh[DATA_W-2:0], samp};
                    pend <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/spi_xfer_checks.sv
module spi_xfer_checks #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_master,
    input logic             idle_high,
    input logic             tx_lead,
    input logic [DIV_W-1:0] half_div,
    input logic             wr_en,
    input logic             rd_en,
    input logic             buf_full,
    input logic             busy,
    input logic             wcol,
    input logic             sck_o,
    input logic             sdo
);
    localparam int TW = $clog2(2 * DATA_W * (1 << DIV_W) + 2);

    logic [TW-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst)                               ticks <= '0;
        else if (wr_en && !busy && mode_master) ticks <= TW'(1);
        else if (busy)                         ticks <= ticks + 1'b1;
    end

    p_idle_level_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_master && !busy) |-> (sck_o == idle_high));

    p_tx_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_master && busy && $past(busy) && $changed(sdo))
            |-> ($changed(sck_o) && (sck_o == (tx_lead ? !idle_high : idle_high))));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !busy) |=> !buf_full);

    p_full_source_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full) |-> $past(busy));

    p_collision_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> wcol);

    p_length_r10: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && mode_master) |-> (ticks == TW'(2 * DATA_W * (int'(half_div) + 1) + 1)));
endmodule

bind spi_xfer_engine spi_xfer_checks #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_checks (
    .clk(clk), .rst(rst), .mode_master(mode_master), .idle_high(idle_high),
    .tx_lead(tx_lead), .half_div(half_div), .wr_en(wr_en), .rd_en(rd_en),
    .buf_full(buf_full), .busy(busy), .wcol(wcol), .sck_o(sck_o), .sdo(sdo)
);

// File: tb/test_spi_xfer_engine.sv
`timescale 1ns/1ps
module test_spi_xfer_engine;
    logic       clk = 0;
    logic       rst = 1;
    logic       mode_master = 1, idle_high = 0, tx_lead = 0, sample_end = 0;
    logic [3:0] half_div = 0;
    logic       wr_en = 0, rd_en = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic       buf_full, busy, wcol, sck_o, sdo;
    logic       sck_i = 0, ss_n = 1, sdi;
    logic       p_sdi = 0, s_sdi = 0;

    int n_checks = 0, n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;
    assign sdi = mode_master ? p_sdi : s_sdi;

    spi_xfer_engine i_spi_xfer_engine (
        .clk(clk), .rst(rst), .mode_master(mode_master), .idle_high(idle_high),
        .tx_lead(tx_lead), .sample_end(sample_end), .half_div(half_div),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .buf_full(buf_full), .busy(busy), .wcol(wcol), .sck_o(sck_o), .sdo(sdo),
        .sck_i(sck_i), .ss_n(ss_n), .sdi(sdi)
    );

    typedef struct { logic [7:0] tx; logic [7:0] rx; string tag; bit slave; } exp_t;
    exp_t sb_q[$];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // peer model for master transfers: real bit only in the half that must be sampled
    bit         p_on = 0, p_end = 0, p_lead = 0;
    logic [7:0] p_byte = 0, p_mosi = 0, s_mosi = 0;
    logic       sck_prev = 0;
    int         ntr = 0;

    always @(negedge clk) begin : peer
        int h;
        int k;
        if (p_on) begin
            if (sck_o !== sck_prev) begin
                ntr++;
                sck_prev = sck_o;
            end
            h = p_lead ? ntr - 1 : ntr;
            if (h < 0)  h = 0;
            if (h > 15) h = 15;
            k = h / 2;
            if (h % 2 == 1) p_mosi[7-k] = sdo;
            p_sdi = ((h % 2) == int'(p_end)) ? p_byte[7-k] : ~p_byte[7-k];
        end
    end

    // monitor: pops expected items as bytes arrive
    always @(negedge clk) begin : monitor
        exp_t it;
        if (rd_en) begin
            rd_en = 0;
            check(!buf_full, "R6", buf_full, 0);
        end else if (buf_full && !rst) begin
            if (sb_q.size() == 0) begin
                check(0, "R6", 1, 0);
            end else begin
                it = sb_q.pop_front();
                check(rd_data == it.rx, it.tag, rd_data, it.rx);
                if (it.slave) check(s_mosi == it.tx, "R8", s_mosi, it.tx);
                else          check(p_mosi == it.tx, "R4", p_mosi, it.tx);
            end
            rd_en = 1;
        end
    end

    task automatic master_xfer(input bit idl, input bit lead, input bit send_end, input int d,
                               input logic [7:0] tx, input logic [7:0] peer, input string tag,
                               input bit coll);
        int n;
        @(negedge clk);
        mode_master = 1; idle_high = idl; tx_lead = lead; sample_end = send_end; half_div = 4'(d);
        ntr = 0; sck_prev = idl; p_mosi = 0; p_end = send_end; p_lead = lead; p_byte = peer; p_on = 1;
        sb_q.push_back('{tx, peer, tag, 1'b0});
        @(negedge clk);
        wr_en = 1; wr_data = tx;
        @(negedge clk);
        wr_en = 0; n = 0;
        check(wcol == 0, "R7", wcol, 0);
        while (!buf_full && n < 1000) begin
            @(negedge clk);
            n++;
            if (coll && n == 5) begin
                wr_en = 1; wr_data = ~tx;
            end else begin
                wr_en = 0;
            end
            if (coll && n == 6) check(wcol == 1, "R7", wcol, 1);
        end
        check(n == 16 * (d + 1), "R10", n, 16 * (d + 1));
        repeat (2) @(negedge clk);
        check(ntr == 16, "R5", ntr, 16);
        check(sck_o == idl, "R5", sck_o, idl);
        p_on = 0;
    endtask

    task automatic slave_xfer(input bit idl, input bit lead, input bit send_end,
                              input logic [7:0] pre, input logic [7:0] mbyte, input string tag);
        @(negedge clk);
        mode_master = 0; idle_high = idl; tx_lead = lead; sample_end = send_end;
        sck_i = idl; ss_n = 1;
        repeat (4) @(negedge clk);
        wr_en = 1; wr_data = pre;
        @(negedge clk);
        wr_en = 0; s_mosi = 0;
        sb_q.push_back('{pre, mbyte, tag, 1'b1});
        repeat (4) @(negedge clk);
        ss_n = 0;
        repeat (8) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            if (!lead) begin
                s_sdi = mbyte[7-k];
                repeat (8) @(negedge clk);
                s_mosi[7-k] = sdo;
                sck_i = ~idl;
                repeat (8) @(negedge clk);
                sck_i = idl;
            end else begin
                sck_i = ~idl;
                s_sdi = mbyte[7-k];
                repeat (8) @(negedge clk);
                s_mosi[7-k] = sdo;
                sck_i = idl;
                repeat (8) @(negedge clk);
            end
        end
        repeat (10) @(negedge clk);
        ss_n = 1;
        repeat (6) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(buf_full == 0, "R1", buf_full, 0);
        check(busy == 0, "R1", busy, 0);
        check(wcol == 0, "R1", wcol, 0);
        check(sck_o == 0, "R1", sck_o, 0);
        idle_high = 1;
        @(negedge clk);
        check(sck_o == 1, "R1", sck_o, 1);

        master_xfer(0, 0, 0, 1,  8'hA5, 8'h3C, "R2", 0);
        master_xfer(0, 1, 1, 2,  8'h81, 8'hC3, "R3", 0);
        master_xfer(1, 0, 1, 0,  8'h5A, 8'h96, "R3", 0);
        master_xfer(1, 1, 0, 3,  8'hF0, 8'h0F, "R2", 0);
        master_xfer(0, 0, 0, 15, 8'h6B, 8'hD2, "R7", 1);
        master_xfer(1, 1, 1, 0,  8'h01, 8'h80, "R3", 0);
        master_xfer(0, 1, 0, 0,  8'hC7, 8'h5D, "R2", 0);

        slave_xfer(0, 0, 0, 8'hC5, 8'h3A, "R8");
        slave_xfer(1, 1, 0, 8'h96, 8'hE1, "R8");
        slave_xfer(0, 1, 1, 8'h2D, 8'hB4, "R9");
        slave_xfer(1, 0, 1, 8'h73, 8'h4E, "R9");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R6", sb_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule